// File: doc/BRIEF.md
# SerDes Mode and Direction Controller

This block is the control plane of a bidirectional 12-bit serializer/deserializer. It takes a two-bit range select, a direction input, a multiplier-select input and a reference-clock activity pulse. From these it decides whether the link is powered down, serializing or deserializing. When both range-select bits are low, the block holds everything in power-down and clears all of its internal state. Any other range-select value names one of three reference-frequency bands. In those bands the direction input chooses serialize (1) or deserialize (0).

Leaving power-down is gated by a reference-clock monitor. The monitor must count a set number of activity pulses before the link is enabled. A run of idle cycles without any pulse throws the monitor back into its waiting state. The parallel-pin output enable drops at once when the link turns toward serializing. It rises only after a settling interval of deserializer operation, so the parallel bus has time to hand over. The inverted direction output is a purely combinational copy, intended to drive the direction input of a link partner. Frequency synthesis is not part of this block.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: While `rng_sel` is 2'b00, `pwr_down` is 1 and `ser_en`, `des_en`, `par_oe` and `frac_mul` are 0 in the same cycle. Every clock edge that samples 2'b00 also clears the activity count, the idle counter and the settle counter.
- R2: While the link is active, `mode_code` equals `rng_sel`, with bit 1 the upper range select and bit 0 the lower; its value is 1, 2 or 3. While `pwr_down` is 1, `mode_code` is 0.
- R3: While the link is active, `dir_in`=1 gives `ser_en`=1, `des_en`=0, and `dir_in`=0 gives `des_en`=1, `ser_en`=0. Both are 0 while powered down, and they are never 1 together.
- R4: `dir_out` is the inverse of `dir_in` at all times, including reset and power-down, with no clock involved.
- R5: `frac_mul` is 1 exactly when `ser_en` is 1 and `mul_sel` is 0; `mul_sel` has no effect while deserializing or powered down.
- R6: With `rng_sel` nonzero, `pwr_down` stays 1 until EDGE_CNT `ref_edge` pulses have been sampled since the count was last cleared. It falls in the cycle after the clock edge that samples the last of them.
- R7: LOSS_TO consecutive sampled cycles with `ref_edge`=0 clear the activity count while waiting. While active, the same condition returns the block to waiting, so `pwr_down` is 1 from the next cycle.
- R8: `par_oe` is 0 in any cycle in which `dir_in` is 1, so it falls in the same cycle the direction turns to serializing.
- R9: `par_oe` becomes 1 only after SETTLE consecutive clock edges that sampled `des_en`=1, and stays 1 while `des_en` stays 1.
- R10: While the asynchronous reset is applied, and for two clock edges after its release, `pwr_down` is 1 and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rng_sel | input | 2 | Range select; 2'b00 requests power-down |
| dir_in | input | 1 | 1 = serialize, 0 = deserialize |
| mul_sel | input | 1 | 0 = fractional (overclocked) multiplier, 1 = integer multiplier |
| ref_edge | input | 1 | One-cycle pulse per detected reference-clock edge, synchronous to clk |
| dir_out | output | 1 | Combinational inverse of dir_in for the link partner |
| pwr_down | output | 1 | 1 while powered down or waiting for reference activity |
| ser_en | output | 1 | Serializer enable |
| des_en | output | 1 | Deserializer enable |
| par_oe | output | 1 | Parallel pin output enable (deserializer drives the pins) |
| frac_mul | output | 1 | Fractional multiplier in use by the serializer |
| mode_code | output | 2 | Observed operating mode, 0 when powered down |

## Verification
The hardest state to reach from the ports is the exact boundary of the activity monitor. An idle gap one cycle shorter than LOSS_TO must leave a partial count intact, and a gap of exactly LOSS_TO must erase it. The bench sweeps the pulse spacing from every cycle up to one cycle past the timeout, for each range band, and compares every output each cycle against an arithmetic model of the count and idle counters. Direction flips with hold times from one cycle upward then probe the settling counter just below, at and above SETTLE.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic {
    MON_WAIT = 1'b0,
    MON_LIVE = 1'b1
  } mon_state_e;
endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/smc_ref_mon.sv
module smc_ref_mon
  import smc_pkg::*;
#(
  parameter int EDGE_CNT = 4,
  parameter int LOSS_TO  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic edge_i,
  output logic live_o
);
  localparam int CW = $clog2(EDGE_CNT + 1);
  localparam int GW = $clog2(LOSS_TO + 1);

  mon_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] gap_q, gap_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    gap_d   = gap_q;
    if (clr) begin
      state_d = MON_WAIT;
      cnt_d   = '0;
      gap_d   = '0;
    end else if (edge_i) begin
      gap_d = '0;
      if (state_q == MON_WAIT) begin
        if (cnt_q == CW'(EDGE_CNT - 1)) begin
          state_d = MON_LIVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end else if (gap_q == GW'(LOSS_TO - 1)) begin
      gap_d   = '0;
      cnt_d   = '0;
      state_d = MON_WAIT;
    end else begin
      gap_d = gap_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MON_WAIT;
      cnt_q   <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
    end
  end

  assign live_o = (state_q == MON_LIVE);
endmodule

// File: rtl/smc_oe_seq.sv
module smc_oe_seq #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic oe_ok
);
  generate
    if (SETTLE == 0) begin : g_direct
      assign oe_ok = arm;
    end else begin : g_count
      localparam int SW = $clog2(SETTLE + 1);
      logic [SW-1:0] cnt_q, cnt_d;
      logic          done;

      assign done = (cnt_q == SW'(SETTLE));

      always_comb begin
        if (!arm)      cnt_d = '0;
        else if (done) cnt_d = cnt_q;
        else           cnt_d = cnt_q + SW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign oe_ok = arm && done;
    end
  endgenerate
endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl #(
  parameter int EDGE_CNT = 4,
  parameter int LOSS_TO  = 8,
  parameter int SETTLE   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rng_sel,
  input  logic       dir_in,
  input  logic       mul_sel,
  input  logic       ref_edge,
  output logic       dir_out,
  output logic       pwr_down,
  output logic       ser_en,
  output logic       des_en,
  output logic       par_oe,
  output logic       frac_mul,
  output logic [1:0] mode_code
);
  logic rst_s_n;
  logic pd_req;
  logic live;
  logic active;
  logic oe_ok;

  smc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign pd_req = (rng_sel == 2'b00);

  smc_ref_mon #(.EDGE_CNT(EDGE_CNT), .LOSS_TO(LOSS_TO)) u_ref_mon (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr    (pd_req),
    .edge_i (ref_edge),
    .live_o (live)
  );

  assign active = !pd_req && live;

  smc_oe_seq #(.SETTLE(SETTLE)) u_oe_seq (
    .clk   (clk),
    .rst_n (rst_s_n),
    .arm   (des_en),
    .oe_ok (oe_ok)
  );

  always_comb begin
    dir_out   = !dir_in;
    pwr_down  = !active;
    ser_en    = active && dir_in;
    des_en    = active && !dir_in;
    par_oe    = oe_ok;
    frac_mul  = ser_en && !mul_sel;
    mode_code = active ? rng_sel : 2'b00;
  end
endmodule

// File: rtl/smc_chk.sv
module smc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rng_sel,
  input logic       dir_in,
  input logic       ref_edge,
  input logic       dir_out,
  input logic       pwr_down,
  input logic       ser_en,
  input logic       des_en,
  input logic       par_oe,
  input logic       frac_mul,
  input logic [1:0] mode_code
);
  AST_PD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_sel == 2'b00) |-> (pwr_down && !ser_en && !des_en && !par_oe && !frac_mul)); // R1

  AST_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |-> (mode_code == rng_sel && rng_sel != 2'b00)); // R2

  AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ser_en, des_en})); // R3

  AST_DIR_INV: assert property (@(posedge clk) disable iff (!rst_n)
    dir_out != dir_in); // R4

  AST_FRAC_SER: assert property (@(posedge clk) disable iff (!rst_n)
    frac_mul |-> ser_en); // R5

  AST_WAKE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> $past(ref_edge)); // R6

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in |-> !par_oe); // R8

  AST_OE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_oe) |-> ($past(des_en) && des_en)); // R9
endmodule

bind serdes_mode_ctrl smc_chk u_smc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rng_sel   (rng_sel),
  .dir_in    (dir_in),
  .ref_edge  (ref_edge),
  .dir_out   (dir_out),
  .pwr_down  (pwr_down),
  .ser_en    (ser_en),
  .des_en    (des_en),
  .par_oe    (par_oe),
  .frac_mul  (frac_mul),
  .mode_code (mode_code)
);

// File: tb/test_serdes_mode_ctrl.sv
module test_serdes_mode_ctrl;
  localparam int EDGE_CNT = 4;
  localparam int LOSS_TO  = 8;
  localparam int SETTLE   = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rng_sel;
  logic       dir_in, mul_sel, ref_edge;
  logic       dir_out, pwr_down, ser_en, des_en, par_oe, frac_mul;
  logic [1:0] mode_code;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  // bench model state
  bit m_live;
  int m_cnt, m_gap, m_settle;

  always #5 clk = !clk;

  serdes_mode_ctrl #(.EDGE_CNT(EDGE_CNT), .LOSS_TO(LOSS_TO), .SETTLE(SETTLE)) i_serdes_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .rng_sel(rng_sel), .dir_in(dir_in), .mul_sel(mul_sel),
    .ref_edge(ref_edge), .dir_out(dir_out), .pwr_down(pwr_down), .ser_en(ser_en),
    .des_en(des_en), .par_oe(par_oe), .frac_mul(frac_mul), .mode_code(mode_code)
  );

  task automatic chk(input string tag, input string ctx, input int got, input int exp);
    if (got != exp) begin
      nerr++;
      $display("FAIL %s (%s) t=%0t: got %0d expected %0d", tag, ctx, $time, got, exp);
    end
  endtask

  task automatic model_clear();
    m_live = 0; m_cnt = 0; m_gap = 0; m_settle = 0;
  endtask

  // One cycle: drive at negedge, compare, advance model at posedge.
  task automatic cyc(input logic [1:0] rs, input logic d, input logic m, input logic e,
                     input string ctx);
    bit act, live_old;
    rng_sel = rs; dir_in = d; mul_sel = m; ref_edge = e;
    #1;
    act = (rs != 2'b00) && m_live;
    nvec++;
    chk("R6 pwr_down", ctx, int'(pwr_down), int'(!act));
    chk("R3 ser_en",   ctx, int'(ser_en),   int'(act && d));
    chk("R3 des_en",   ctx, int'(des_en),   int'(act && !d));
    chk("R9 par_oe",   ctx, int'(par_oe),   int'(act && !d && m_settle == SETTLE));
    chk("R5 frac_mul", ctx, int'(frac_mul), int'(act && d && !m));
    chk("R2 mode",     ctx, int'(mode_code), act ? int'(rs) : 0);
    chk("R4 dir_out",  ctx, int'(dir_out),  int'(!d));
    @(posedge clk);
    live_old = m_live;
    if (rs == 2'b00) begin
      model_clear();
    end else begin
      if (e) begin
        m_gap = 0;
        if (!m_live) begin
          if (m_cnt == EDGE_CNT - 1) begin m_live = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end else if (m_gap == LOSS_TO - 1) begin
        m_gap = 0; m_cnt = 0; m_live = 0;
      end else begin
        m_gap++;
      end
      if (live_old && !d) m_settle = (m_settle < SETTLE) ? m_settle + 1 : SETTLE;
      else                m_settle = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rng_sel = 2'b01; dir_in = 1'b1; mul_sel = 1'b0; ref_edge = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset holds power-down even with edges and a valid range
    nvec++;
    chk("R10 pwr_down", "reset", int'(pwr_down), 1);
    chk("R10 ser_en", "reset", int'(ser_en), 0);
    chk("R4 dir_out", "reset", int'(dir_out), 0);
    dir_in = 1'b0; #1;
    nvec++;
    chk("R10 des_en", "reset", int'(des_en), 0);
    chk("R4 dir_out", "reset", int'(dir_out), 1);
    rng_sel = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();

    // R6: wake-up with an edge every cycle
    for (int k = 0; k < EDGE_CNT + 3; k++) cyc(2'b01, 1'b1, 1'b1, 1'b1, "R6 wake");

    // R1/R2/R3/R5: sweep every select, direction and multiplier combination
    for (int rs = 0; rs < 4; rs++)
      for (int d = 0; d < 2; d++)
        for (int m = 0; m < 2; m++)
          for (int k = 0; k < EDGE_CNT + SETTLE + 2; k++)
            cyc(2'(rs), 1'(d), 1'(m), 1'b1, "R1 sweep");

    // R7: pulse spacing from 1 to one past the idle timeout, each band
    for (int sp = 1; sp <= LOSS_TO + 2; sp++)
      for (int rs = 1; rs < 4; rs++) begin
        cyc(2'b00, 1'b0, 1'b0, 1'b0, "R1 clear");
        cyc(2'b00, 1'b0, 1'b0, 1'b0, "R1 clear");
        for (int k = 0; k < 5 * sp + 4 * LOSS_TO; k++)
          cyc(2'(rs), 1'(k / 7 % 2), 1'(k / 3 % 2), 1'((k % sp) == 0), "R7 spacing");
      end

    // R7: partial count kept across a short gap, lost across a full gap
    cyc(2'b00, 1'b0, 1'b0, 1'b0, "R1 clear");
    for (int k = 0; k < EDGE_CNT - 1; k++) cyc(2'b10, 1'b0, 1'b0, 1'b1, "R7 partial");
    for (int k = 0; k < LOSS_TO - 1; k++) cyc(2'b10, 1'b0, 1'b0, 1'b0, "R7 short gap");
    for (int k = 0; k < 3; k++) cyc(2'b10, 1'b0, 1'b0, 1'b1, "R7 resume");
    for (int k = 0; k < LOSS_TO + 1; k++) cyc(2'b10, 1'b0, 1'b0, 1'b0, "R7 live loss");

    // R8/R9: direction flips with hold times around the settling interval
    for (int k = 0; k < EDGE_CNT + 1; k++) cyc(2'b11, 1'b0, 1'b1, 1'b1, "R6 rewake");
    for (int h = 1; h <= SETTLE + 3; h++) begin
      for (int k = 0; k < h; k++) cyc(2'b11, 1'b0, 1'b1, 1'b1, "R9 settle");
      for (int k = 0; k < h; k++) cyc(2'b11, 1'b1, 1'(h % 2), 1'b1, "R8 drop");
    end
    for (int k = 0; k < SETTLE + 2; k++) cyc(2'b11, 1'b0, 1'b0, 1'b1, "R9 hold");
    cyc(2'b11, 1'b1, 1'b0, 1'b1, "R8 immediate");
    cyc(2'b00, 1'b0, 1'b1, 1'b1, "R1 force");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule